// File: doc/BRIEF.md
# Linked-Page Transmit Descriptor Walker

This block sits on the device side of a CAN-FD transmit path and fetches queued frame records from host memory. The host fills fixed-size pages with variable-length records. The last record on each page is a link record that names the 64-bit address of the next page. The host posts one strobe to a request port for each frame it has written. For each strobe, the walker reads the next record header through a single-outstanding memory read port. It then hands the record's address and length to the frame engine downstream.

When the walker meets a link record, it reads the two address words that follow the header and replaces its read pointer with them. It also pulses a link event, which lets the host reclaim the page it just left. The path is configured while it is held stopped. The host loads the start address in two 32-bit halves and then clears the hold bit. Walking then begins at that address. A malformed length stops the walker and raises a sticky error.

Top module: `txw_walker`

## Requirements
- R1: After reset the path is held (control bit 0 = 1). While the path is held, no memory read is issued, `msg_vld` and `link_evt` stay low, and `err_flag` is cleared.
- R2: A host write with `host_sel` 0 loads address bits 31:0 of the start register, and `host_sel` 1 loads bits 63:32. Both take effect only while the path is held; such writes are ignored while it runs.
- R3: A write with `host_sel` 4 and `host_wdata` bit 0 set adds one pending request, and with bit 0 clear it has no effect. The pending count saturates at 2^CNT_W-1 and is cleared (and kept at zero) while the path is held.
- R4: With no pending request, the walker issues no memory read.
- R5: Each record starts with one 32-bit word: bits 15:0 hold the length in bytes and bits 31:16 hold the type. For a type other than 0x1001, the walker pulses `msg_vld` for one cycle with the record address and length, advances its pointer by the length, and removes one pending request.
- R6: A record of type 0x1001 is a link. The walker reads the words at pointer+4 (low address) and pointer+8 (high address) and moves to that address. It pulses `link_evt` for one cycle, gives no `msg_vld`, and removes no pending request.
- R7: A length of zero, or a length that is not a multiple of 4, sets `err_flag`. The flag stays set, and no further read or message follows until the path is held again.
- R8: Clearing the hold bit (a write with `host_sel` 3 and bit 0 set) starts walking at the loaded start address. Setting it (`host_sel` 2, bit 0 set) stops the walker.
- R9: `mem_rd_req` is a one-cycle strobe, and a new read is issued only after the previous read's `mem_rd_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 3 | Host register select: 0 addr low, 1 addr high, 2 control set, 3 control clear, 4 request |
| host_wdata | input | 32 | Host write data |
| mem_rd_req | output | 1 | Memory read request strobe |
| mem_rd_addr | output | ADDR_W | Byte address of the 32-bit word to read |
| mem_rd_vld | input | 1 | Read response valid |
| mem_rd_data | input | 32 | Read response word |
| msg_vld | output | 1 | One-cycle pulse: a frame record was consumed |
| msg_addr | output | ADDR_W | Address of the consumed record |
| msg_size | output | 16 | Length of the consumed record in bytes |
| link_evt | output | 1 | One-cycle pulse: a link record was followed |
| err_flag | output | 1 | Sticky malformed-record flag |

## Verification
The bench builds two pages that link to each other, with their high address words differing. A walker that dropped the high word, or that decremented the pending count on a link, would deliver the wrong addresses or too few frames. The bench stalls memory while it posts more strobes than the counter holds, so a counter that wrapped instead of saturating would release the wrong number of frames. It writes the start register while the path runs and then restarts, which exposes a register that took the write. Records with an odd length and with zero length check that the walker stops cold rather than skipping ahead by a bad amount.

// File: rtl/txw_pkg.sv
package txw_pkg;

   // host register selects
   localparam logic [2:0] SEL_ADDR_LO = 3'd0;
   localparam logic [2:0] SEL_ADDR_HI = 3'd1;
   localparam logic [2:0] SEL_CTL_SET = 3'd2;
   localparam logic [2:0] SEL_CTL_CLR = 3'd3;
   localparam logic [2:0] SEL_REQ     = 3'd4;

   // record type that redirects the read pointer
   localparam logic [15:0] LINK_KIND = 16'h1001;

   typedef struct packed {
      logic [15:0] kind;
      logic [15:0] len;
   } rec_hdr_t;

   typedef enum logic [3:0] {
      ST_HALT,
      ST_IDLE,
      ST_HDR_RQ,
      ST_HDR_WT,
      ST_LO_RQ,
      ST_LO_WT,
      ST_HI_RQ,
      ST_HI_WT,
      ST_ERR
   } walk_st_e;

endpackage

// File: rtl/txw_host_regs.sv
module txw_host_regs
   import txw_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [2:0]        host_sel,
   input  logic [31:0]       host_wdata,
   output logic              path_hold,
   output logic [ADDR_W-1:0] base_addr,
   output logic              req_pulse
);

   logic wr_set, wr_clr, wr_lo, wr_hi;

   assign wr_set    = host_we && (host_sel == SEL_CTL_SET) && host_wdata[0];
   assign wr_clr    = host_we && (host_sel == SEL_CTL_CLR) && host_wdata[0];
   assign wr_lo     = host_we && (host_sel == SEL_ADDR_LO) && path_hold;
   assign wr_hi     = host_we && (host_sel == SEL_ADDR_HI) && path_hold;
   assign req_pulse = host_we && (host_sel == SEL_REQ) && host_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      path_hold <= 1'b1;
      else if (wr_set) path_hold <= 1'b1;
      else if (wr_clr) path_hold <= 1'b0;
   end

   generate
      if (ADDR_W > 32) begin : g_wide
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               base_addr <= '0;
            end else begin
               if (wr_lo) base_addr[31:0]       <= host_wdata;
               if (wr_hi) base_addr[ADDR_W-1:32] <= host_wdata[ADDR_W-33:0];
            end
         end
      end else begin : g_narrow
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     base_addr <= '0;
            else if (wr_lo) base_addr <= host_wdata[ADDR_W-1:0];
         end
      end
   endgenerate

endmodule

// File: rtl/txw_req_acc.sv
module txw_req_acc #(
   parameter int CNT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic inc,
   input  logic dec,
   output logic pending
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else begin
         case ({inc, dec})
            2'b10:   if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            2'b01:   if (cnt != '0)      cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign pending = (cnt != '0);

endmodule

// File: rtl/txw_hdr_check.sv
module txw_hdr_check
   import txw_pkg::*;
#(
   parameter int ALIGN_BYTES = 4
) (
   input  logic [31:0] word,
   output logic [15:0] len,
   output logic        is_link,
   output logic        bad
);

   localparam logic [15:0] AL_MASK = 16'(ALIGN_BYTES - 1);

   rec_hdr_t hdr;
   logic     misalign;

   assign hdr     = rec_hdr_t'(word);
   assign len     = hdr.len;
   assign is_link = (hdr.kind == LINK_KIND);

   generate
      if (ALIGN_BYTES > 1) begin : g_align
         assign misalign = |(hdr.len & AL_MASK);
      end else begin : g_noalign
         assign misalign = 1'b0;
      end
   endgenerate

   assign bad = (hdr.len == 16'd0) || misalign;

endmodule

// File: rtl/txw_walk_fsm.sv
module txw_walk_fsm
   import txw_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic [ADDR_W-1:0] base,
   input  logic              pending,
   input  logic              rsp_vld,
   input  logic [31:0]       rsp_data,
   input  logic [15:0]       hdr_len,
   input  logic              hdr_is_link,
   input  logic              hdr_bad,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              consume,
   output logic              msg_vld,
   output logic [ADDR_W-1:0] msg_addr,
   output logic [15:0]       msg_size,
   output logic              link_evt,
   output logic              err_flag
);

   walk_st_e          st;
   logic [ADDR_W-1:0] ptr;
   logic [31:0]       lo_word;
   logic [ADDR_W-1:0] link_target;

   generate
      if (ADDR_W > 32) begin : g_wide
         assign link_target = {rsp_data[ADDR_W-33:0], lo_word};
      end else begin : g_narrow
         assign link_target = lo_word[ADDR_W-1:0];
      end
   endgenerate

   always_comb begin
      rd_req  = 1'b0;
      rd_addr = ptr;
      case (st)
         ST_HDR_RQ: rd_req = 1'b1;
         ST_LO_RQ: begin rd_req = 1'b1; rd_addr = ptr + ADDR_W'(4); end
         ST_HI_RQ: begin rd_req = 1'b1; rd_addr = ptr + ADDR_W'(8); end
         default: ;
      endcase
   end

   assign consume = (st == ST_HDR_WT) && rsp_vld && !hdr_bad && !hdr_is_link && !hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_HALT;
         ptr      <= '0;
         lo_word  <= '0;
         msg_vld  <= 1'b0;
         msg_addr <= '0;
         msg_size <= '0;
         link_evt <= 1'b0;
         err_flag <= 1'b0;
      end else begin
         msg_vld  <= 1'b0;
         link_evt <= 1'b0;
         if (hold) begin
            st       <= ST_HALT;
            ptr      <= base;
            err_flag <= 1'b0;
         end else begin
            case (st)
               ST_HALT:   st <= ST_IDLE;
               ST_IDLE:   if (pending) st <= ST_HDR_RQ;
               ST_HDR_RQ: st <= ST_HDR_WT;
               ST_HDR_WT: if (rsp_vld) begin
                  if (hdr_bad) begin
                     err_flag <= 1'b1;
                     st       <= ST_ERR;
                  end else if (hdr_is_link) begin
                     st <= ST_LO_RQ;
                  end else begin
                     msg_vld  <= 1'b1;
                     msg_addr <= ptr;
                     msg_size <= hdr_len;
                     ptr      <= ptr + ADDR_W'(hdr_len);
                     st       <= ST_IDLE;
                  end
               end
               ST_LO_RQ:  st <= ST_LO_WT;
               ST_LO_WT:  if (rsp_vld) begin
                  lo_word <= rsp_data;
                  st      <= ST_HI_RQ;
               end
               ST_HI_RQ:  st <= ST_HI_WT;
               ST_HI_WT:  if (rsp_vld) begin
                  ptr      <= link_target;
                  link_evt <= 1'b1;
                  st       <= ST_IDLE;
               end
               default:   st <= ST_ERR;
            endcase
         end
      end
   end

endmodule

// File: rtl/txw_walker.sv
module txw_walker
   import txw_pkg::*;
#(
   parameter int ADDR_W      = 64,
   parameter int CNT_W       = 8,
   parameter int ALIGN_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [2:0]        host_sel,
   input  logic [31:0]       host_wdata,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_vld,
   input  logic [31:0]       mem_rd_data,
   output logic              msg_vld,
   output logic [ADDR_W-1:0] msg_addr,
   output logic [15:0]       msg_size,
   output logic              link_evt,
   output logic              err_flag
);

   generate
      if (ADDR_W < 16 || ADDR_W > 64) begin : g_bad_addr_w
         $error("txw_walker: ADDR_W must lie in 16..64");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
         $error("txw_walker: CNT_W must lie in 1..16");
      end
      if (ALIGN_BYTES < 1 || (ALIGN_BYTES & (ALIGN_BYTES - 1)) != 0) begin : g_bad_align
         $error("txw_walker: ALIGN_BYTES must be a power of two");
      end
   endgenerate

   logic              path_hold;
   logic [ADDR_W-1:0] base_addr;
   logic              req_pulse;
   logic              pending;
   logic              consume;
   logic [15:0]       hdr_len;
   logic              hdr_is_link;
   logic              hdr_bad;

   txw_host_regs #(.ADDR_W(ADDR_W)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_sel   (host_sel),
      .host_wdata (host_wdata),
      .path_hold  (path_hold),
      .base_addr  (base_addr),
      .req_pulse  (req_pulse)
   );

   txw_req_acc #(.CNT_W(CNT_W)) acc_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (path_hold),
      .inc     (req_pulse),
      .dec     (consume),
      .pending (pending)
   );

   txw_hdr_check #(.ALIGN_BYTES(ALIGN_BYTES)) hdr_i (
      .word    (mem_rd_data),
      .len     (hdr_len),
      .is_link (hdr_is_link),
      .bad     (hdr_bad)
   );

   txw_walk_fsm #(.ADDR_W(ADDR_W)) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold        (path_hold),
      .base        (base_addr),
      .pending     (pending),
      .rsp_vld     (mem_rd_vld),
      .rsp_data    (mem_rd_data),
      .hdr_len     (hdr_len),
      .hdr_is_link (hdr_is_link),
      .hdr_bad     (hdr_bad),
      .rd_req      (mem_rd_req),
      .rd_addr     (mem_rd_addr),
      .consume     (consume),
      .msg_vld     (msg_vld),
      .msg_addr    (msg_addr),
      .msg_size    (msg_size),
      .link_evt    (link_evt),
      .err_flag    (err_flag)
   );

endmodule

// File: rtl/txw_walker_chk.sv
module txw_walker_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        hold,
   input logic        mem_rd_req,
   input logic        mem_rd_vld,
   input logic        msg_vld,
   input logic [15:0] msg_size,
   input logic        link_evt,
   input logic        err_flag
);

   logic outst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          outst <= 1'b0;
      else if (hold)       outst <= 1'b0;
      else if (mem_rd_req) outst <= 1'b1;
      else if (mem_rd_vld) outst <= 1'b0;
   end

   a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !outst);

   a_r9_req_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |=> !mem_rd_req);

   a_r1_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && $past(hold)) |-> (!mem_rd_req && !msg_vld && !link_evt));

   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !hold) |=> err_flag);

   a_r7_err_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |-> (!mem_rd_req && !msg_vld));

   a_r6_link_not_msg: assert property (@(posedge clk) disable iff (!rst_n)
      !(link_evt && msg_vld));

   a_r5_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
      msg_vld |-> (msg_size != 16'd0 && msg_size[1:0] == 2'b00));

endmodule

bind txw_walker txw_walker_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .hold       (path_hold),
   .mem_rd_req (mem_rd_req),
   .mem_rd_vld (mem_rd_vld),
   .msg_vld    (msg_vld),
   .msg_size   (msg_size),
   .link_evt   (link_evt),
   .err_flag   (err_flag)
);

// File: tb/txw_walker_tb.sv
module txw_walker_tb_top;
   import txw_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 4;
   localparam int PAGE_BYTES = 256;
   localparam longint unsigned PG0 = 64'h0000_0001_0000_1000;
   localparam longint unsigned PG1 = 64'h0000_0002_0000_0800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [2:0]  host_sel = '0;
   logic [31:0] host_wdata = '0;
   logic        mem_rd_req;
   logic [63:0] mem_rd_addr;
   logic        mem_rd_vld = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        msg_vld;
   logic [63:0] msg_addr;
   logic [15:0] msg_size;
   logic        link_evt;
   logic        err_flag;

   txw_walker #(.ADDR_W(64), .CNT_W(CNT_W), .ALIGN_BYTES(4)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_vld(mem_rd_vld), .mem_rd_data(mem_rd_data),
      .msg_vld(msg_vld), .msg_addr(msg_addr), .msg_size(msg_size),
      .link_evt(link_evt), .err_flag(err_flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // memory image and model
   bit [31:0] mem [longint unsigned];
   bit        busy = 1'b0;
   bit        stall = 1'b0;
   int        lat_left = 0;
   longint unsigned pend_addr = 0;

   function automatic bit [31:0] rd_mem(longint unsigned a);
      if (mem.exists(a)) return mem[a];
      return 32'h0;
   endfunction

   always @(negedge clk) begin
      mem_rd_vld = 1'b0;
      if (busy && !stall) begin
         if (lat_left == 0) begin
            mem_rd_vld  = 1'b1;
            mem_rd_data = rd_mem(pend_addr);
            busy        = 1'b0;
         end else begin
            lat_left--;
         end
      end
      if (mem_rd_req) begin
         busy      = 1'b1;
         pend_addr = mem_rd_addr;
         lat_left  = $urandom_range(0, 2);
      end
   end

   // monitor
   longint unsigned obs_addr[$];
   int              obs_size[$];
   int              links_seen = 0;
   int              reqs_seen = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (msg_vld) begin
            obs_addr.push_back(msg_addr);
            obs_size.push_back(int'(msg_size));
         end
         if (link_evt) links_seen++;
         if (mem_rd_req) reqs_seen++;
      end
   end

   // page contents, recorded when built
   longint unsigned pg_addr[2][$];
   int              pg_size[2][$];
   longint unsigned exp_addr[$];
   int              exp_size[$];
   int              exp_links;

   task automatic check(bit ok, string req, longint unsigned act, longint unsigned exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic host_wr(logic [2:0] sel, logic [31:0] data);
      @(negedge clk);
      host_we = 1'b1; host_sel = sel; host_wdata = data;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_obs();
      obs_addr.delete(); obs_size.delete();
      links_seen = 0; reqs_seen = 0;
   endtask

   task automatic wait_msgs(int n, int limit);
      for (int i = 0; i < limit && obs_addr.size() < n; i++) @(negedge clk);
   endtask

   task automatic build_page(int p, longint unsigned base, longint unsigned nxt);
      int off = 0;
      int sz;
      bit [15:0] kind;
      sz = 4 * $urandom_range(2, 19);
      while (off + sz + 12 <= PAGE_BYTES) begin
         kind = 16'h0100 + 16'($urandom_range(0, 15));
         mem[base + off] = {kind, 16'(sz)};
         pg_addr[p].push_back(base + off);
         pg_size[p].push_back(sz);
         off += sz;
         sz = 4 * $urandom_range(2, 19);
      end
      mem[base + off]     = {LINK_KIND, 16'd12};
      mem[base + off + 4] = nxt[31:0];
      mem[base + off + 8] = nxt[63:32];
   endtask

   // expected order of n records starting at the top of page 0
   task automatic expect_msgs(int n);
      int p = 0;
      int k = 0;
      exp_addr.delete(); exp_size.delete(); exp_links = 0;
      for (int i = 0; i < n; i++) begin
         if (k == pg_addr[p].size()) begin
            p = 1 - p; k = 0; exp_links++;
         end
         exp_addr.push_back(pg_addr[p][k]);
         exp_size.push_back(pg_size[p][k]);
         k++;
      end
   endtask

   task automatic compare_run(int n, string tag);
      expect_msgs(n);
      check(obs_addr.size() == n, {tag, " R5 record count"}, obs_addr.size(), n);
      for (int i = 0; i < n && i < obs_addr.size(); i++) begin
         check(obs_addr[i] == exp_addr[i], {tag, " R5/R6 record address"}, obs_addr[i], exp_addr[i]);
         check(obs_size[i] == exp_size[i], {tag, " R5 record length"}, obs_size[i], exp_size[i]);
      end
      check(links_seen == exp_links, {tag, " R6 link events"}, links_seen, exp_links);
      check(reqs_seen == n + 3 * exp_links, {tag, " R9 memory reads"}, reqs_seen, n + 3 * exp_links);
   endtask

   task automatic restart(longint unsigned base);
      host_wr(SEL_CTL_SET, 32'h1);
      host_wr(SEL_ADDR_LO, base[31:0]);
      host_wr(SEL_ADDR_HI, base[63:32]);
      idle(2);
      clear_obs();
      host_wr(SEL_CTL_CLR, 32'h1);
   endtask

   initial begin
      void'($urandom(32'd2718));
      build_page(0, PG0, PG1);
      build_page(1, PG1, PG0);
      mem[64'h3000] = {16'h0100, 16'd6};
      mem[64'h4000] = 32'h0;

      idle(5);
      check(mem_rd_req == 1'b0, "R1 reset read strobe", mem_rd_req, 0);
      check(msg_vld == 1'b0,    "R1 reset msg_vld", msg_vld, 0);
      check(link_evt == 1'b0,   "R1 reset link_evt", link_evt, 0);
      check(err_flag == 1'b0,   "R1 reset err_flag", err_flag, 0);
      rst_n = 1'b1;
      idle(3);

      // R3: strobes while held are dropped; R2: base loads while held
      host_wr(SEL_ADDR_LO, PG0[31:0]);
      host_wr(SEL_ADDR_HI, PG0[63:32]);
      host_wr(SEL_REQ, 32'h1);
      host_wr(SEL_REQ, 32'h1);
      clear_obs();
      host_wr(SEL_CTL_CLR, 32'h1);
      idle(20);
      check(reqs_seen == 0, "R3/R4 no fetch after held strobes", reqs_seen, 0);

      // R3: bit 0 clear has no effect
      host_wr(SEL_REQ, 32'hFFFF_FFFE);
      idle(20);
      check(reqs_seen == 0, "R3 even write ignored", reqs_seen, 0);

      // R2: writes while running are ignored
      host_wr(SEL_ADDR_LO, 32'hDEAD_0000);
      host_wr(SEL_ADDR_HI, 32'h0000_0077);

      // random bursts, staying below saturation per burst
      begin
         int total = 0;
         while (total < 40) begin
            int b = $urandom_range(1, 6);
            for (int j = 0; j < b; j++) host_wr(SEL_REQ, 32'h1);
            total += b;
            idle($urandom_range(0, 40));
         end
         wait_msgs(total, 5000);
         idle(30);
         compare_run(total, "burst");
         check(obs_addr.size() > 0 && obs_addr[0] == PG0, "R8 first record at base", obs_addr.size() > 0 ? obs_addr[0] : 0, PG0);
      end

      // R8/R2: restart from loaded base (running writes must not have landed)
      host_wr(SEL_CTL_SET, 32'h1);
      idle(3);
      clear_obs();
      host_wr(SEL_CTL_CLR, 32'h1);
      host_wr(SEL_REQ, 32'h1);
      wait_msgs(1, 200);
      idle(10);
      check(obs_addr.size() == 1 && obs_addr[0] == PG0, "R2/R8 restart address", obs_addr.size() > 0 ? obs_addr[0] : 0, PG0);

      // R3 saturation: memory stalled, 20 strobes posted
      restart(PG0);
      stall = 1'b1;
      for (int j = 0; j < 20; j++) host_wr(SEL_REQ, 32'h1);
      stall = 1'b0;
      wait_msgs(15, 5000);
      idle(60);
      compare_run(15, "R3 saturate");

      // R7: length not a multiple of 4
      restart(64'h3000);
      host_wr(SEL_REQ, 32'h1);
      host_wr(SEL_REQ, 32'h1);
      idle(30);
      check(err_flag == 1'b1, "R7 odd length flags error", err_flag, 1);
      check(obs_addr.size() == 0, "R7 no record on error", obs_addr.size(), 0);
      check(reqs_seen == 1, "R7 reads stop on error", reqs_seen, 1);
      idle(40);
      check(err_flag == 1'b1, "R7 error sticky", err_flag, 1);
      host_wr(SEL_CTL_SET, 32'h1);
      idle(2);
      check(err_flag == 1'b0, "R1 hold clears error", err_flag, 0);

      // R7: zero length
      restart(64'h4000);
      host_wr(SEL_REQ, 32'h1);
      idle(30);
      check(err_flag == 1'b1, "R7 zero length flags error", err_flag, 1);
      check(obs_addr.size() == 0, "R7 zero length no record", obs_addr.size(), 0);

      // R1: hold quiets the walker
      host_wr(SEL_CTL_SET, 32'h1);
      clear_obs();
      host_wr(SEL_REQ, 32'h1);
      idle(20);
      check(reqs_seen == 0 && obs_addr.size() == 0, "R1 held walker idle", reqs_seen, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule